// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is the control unit of a small accumulator-style processor. It steps the machine through the instruction cycle over one shared memory port. It keeps the program counter, the instruction register, the memory address register and the memory buffer register. For each instruction it fetches the word at the program counter, decodes a few mode bits, and then performs these steps in turn:

- It fetches up to two operands, optionally through a pointer word.
- It hands control to an external execution unit.
- It writes up to two results.
- It checks for a pending interrupt before the next fetch.

An interrupt diverts the controller into an interrupt cycle. The cycle stores the program counter to a fixed save location through the memory buffer and then jumps to a fixed handler address.

The memory port is a request/ready handshake. `mem_req` is the valid signal. Once it is raised, the address, direction and write data stay stable until the memory answers with `mem_ready` in the same cycle. Read data is taken in that same cycle. The memory may hold off any access for any number of cycles.

The execution step uses the same rules. `exe_valid` stays high until `exe_ready` is seen, and `res_data` must be stable while result writes are in progress. Each operand read is reported on `opnd_valid`/`opnd_data` as a one-cycle strobe, with no back-pressure.

Top module: `icc_ctrl`

## Requirements
- R1: After reset the program counter is 0, interrupts are disabled and the controller is in the address-calculation step. `mem_req` is low while reset is held, and the first access after reset is a read at address 0.
- R2: Instructions are fetched by reads at consecutive addresses starting from the program counter. The program counter increments once per fetch.
- R3: While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_we` hold their values and `mem_req` stays high. Every access completes exactly once, on the cycle `mem_ready` is high, including when `mem_ready` answers with no wait.
- R4: IR bits 15:14 give the operand count (0, 1 or 2; code 3 acts as 2). Operand k is read at the base address in IR bits 9:0 plus k. Each operand read raises `opnd_valid` with the word read.
- R5: When IR bit 11 is set, every operand and result address is first used to read a pointer word. The access itself then goes to bits 9:0 of that pointer.
- R6: After the last operand, `exe_valid` rises and holds until `exe_ready`. No memory access is made while `exe_valid` is high.
- R7: IR bits 13:12 give the result count (0, 1 or 2; code 3 acts as 2). Result k writes `res_data` to the base address plus k, after the execution step, in increasing k.
- R8: `instr_done` pulses once at the end of each instruction. `irq` has no effect while interrupts are disabled, and the next fetch follows directly.
- R9: With interrupts enabled and `irq` high at the check, the controller writes the next program counter to address 0x3F0. It pulses `irq_ack` on that write, clears the interrupt enable, and fetches next from address 0x100.
- R10: IR bit 10 enables interrupts during the decode of that instruction, so an interrupt can be taken at the end of the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request (valid) |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| opnd_valid | output | 1 | Operand word strobe |
| opnd_data | output | 16 | Operand word |
| exe_valid | output | 1 | Execution step requested |
| exe_ready | input | 1 | Execution step finished |
| res_data | input | 16 | Result word to write |
| irq | input | 1 | Interrupt request level |
| irq_ack | output | 1 | Pulse when the PC save write completes |
| instr_done | output | 1 | Pulse at the end of each instruction |

## Verification
The hardest state to reach is an indirect instruction with both operands and results. In that state the pointer word is read again for the result after the operand phase, and this happens under memory wait states. The bench gets there by loading a program whose pointer and target words are both placed in its memory model, which has a programmable wait count. It then compares the full ordered trace of accesses.

The interrupt path also needs a set-up instruction first, one that enables interrupts while `irq` is already high. With that in place, the save write, the handler fetch and the absence of a second entry all show in one trace.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [3:0] {
    S_IAC, S_IF, S_IRLD, S_DEC, S_OAC, S_IND, S_OPF,
    S_EXE, S_RAC, S_WR, S_ICK, S_INTA, S_INTW
  } icc_state_e;
endpackage

// File: rtl/icc_decode.sv
module icc_decode #(
  parameter int DW = 16,
  localparam int AW = DW - 6
) (
  input  logic [DW-1:0] ir,
  output logic [1:0]    n_opnd,
  output logic [1:0]    n_res,
  output logic          indirect,
  output logic          ie_set,
  output logic [AW-1:0] base
);
  // count code 3 is treated as 2
  always_comb begin
    n_opnd   = (ir[DW-1:DW-2] == 2'd3) ? 2'd2 : ir[DW-1:DW-2];
    n_res    = (ir[DW-3:DW-4] == 2'd3) ? 2'd2 : ir[DW-3:DW-4];
    indirect = ir[DW-5];
    ie_set   = ir[DW-6];
    base     = ir[AW-1:0];
  end
endmodule

// File: rtl/icc_fsm.sv
module icc_fsm
  import icc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_ready,
  input  logic       exe_ready,
  input  logic       irq,
  input  logic       ie,
  input  logic [1:0] n_opnd,
  input  logic [1:0] n_res,
  input  logic       indirect,
  output icc_state_e state,
  output logic [1:0] idx
);
  logic       in_res;
  icc_state_e nxt;
  logic [1:0] idx_inc;

  assign idx_inc = idx + 2'd1;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IAC:  nxt = S_IF;
      S_IF:   if (mem_ready) nxt = S_IRLD;
      S_IRLD: nxt = S_DEC;
      S_DEC:  nxt = (n_opnd != 2'd0) ? S_OAC : S_EXE;
      S_OAC:  nxt = indirect ? S_IND : S_OPF;
      S_IND:  if (mem_ready) nxt = in_res ? S_WR : S_OPF;
      S_OPF:  if (mem_ready) nxt = (idx_inc < n_opnd) ? S_OAC : S_EXE;
      S_EXE:  if (exe_ready) nxt = (n_res != 2'd0) ? S_RAC : S_ICK;
      S_RAC:  nxt = indirect ? S_IND : S_WR;
      S_WR:   if (mem_ready) nxt = (idx_inc < n_res) ? S_RAC : S_ICK;
      S_ICK:  nxt = (irq && ie) ? S_INTA : S_IAC;
      S_INTA: nxt = S_INTW;
      S_INTW: if (mem_ready) nxt = S_IAC;
      default: nxt = S_IAC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IAC;
      idx    <= 2'd0;
      in_res <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_DEC) begin
        idx    <= 2'd0;
        in_res <= 1'b0;
      end else if (state == S_EXE && exe_ready) begin
        idx    <= 2'd0;
        in_res <= 1'b1;
      end else if ((state == S_OPF || state == S_WR) && mem_ready) begin
        idx <= idx_inc;
      end
    end
  end
endmodule

// File: rtl/icc_regs.sv
module icc_regs
  import icc_pkg::*;
#(
  parameter int DW = 16,
  parameter int SAVE_ADDR = 'h3F0,
  parameter int HANDLER_ADDR = 'h100,
  localparam int AW = DW - 6
) (
  input  logic          clk,
  input  logic          rst,
  input  icc_state_e    state,
  input  logic [1:0]    idx,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ie_set,
  input  logic [AW-1:0] base,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic          ie
);
  logic [AW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mbr <= '0;
      ie  <= 1'b0;
    end else begin
      unique case (state)
        S_IAC: mar <= pc;
        S_IF: if (mem_ready) begin
          mbr <= mem_rdata;
          pc  <= pc + AW'(1);
        end
        S_IRLD: ir <= mbr;
        S_DEC:  if (ie_set) ie <= 1'b1;
        S_OAC, S_RAC: mar <= base + AW'(idx);
        S_IND: if (mem_ready) begin
          mbr <= mem_rdata;
          mar <= mem_rdata[AW-1:0];
        end
        S_OPF: if (mem_ready) mbr <= mem_rdata;
        S_INTA: begin
          mbr <= DW'(pc);
          mar <= AW'(SAVE_ADDR);
        end
        S_INTW: if (mem_ready) begin
          pc <= AW'(HANDLER_ADDR);
          ie <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter int DW = 16,
  parameter int SAVE_ADDR = 'h3F0,
  parameter int HANDLER_ADDR = 'h100,
  localparam int AW = DW - 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          opnd_valid,
  output logic [DW-1:0] opnd_data,
  output logic          exe_valid,
  input  logic          exe_ready,
  input  logic [DW-1:0] res_data,
  input  logic          irq,
  output logic          irq_ack,
  output logic          instr_done
);
  icc_state_e    state;
  logic [1:0]    idx, n_opnd, n_res;
  logic          indirect, ie_set, ie;
  logic [DW-1:0] ir, mbr;
  logic [AW-1:0] base, mar;

  icc_decode #(.DW(DW)) u_dec (
    .ir(ir), .n_opnd(n_opnd), .n_res(n_res),
    .indirect(indirect), .ie_set(ie_set), .base(base)
  );

  icc_fsm u_fsm (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .exe_ready(exe_ready),
    .irq(irq), .ie(ie), .n_opnd(n_opnd), .n_res(n_res),
    .indirect(indirect), .state(state), .idx(idx)
  );

  icc_regs #(.DW(DW), .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)) u_regs (
    .clk(clk), .rst(rst), .state(state), .idx(idx), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .ie_set(ie_set), .base(base),
    .ir(ir), .mar(mar), .mbr(mbr), .ie(ie)
  );

  always_comb begin
    mem_req    = (state == S_IF) || (state == S_IND) || (state == S_OPF) ||
                 (state == S_WR) || (state == S_INTW);
    mem_we     = (state == S_WR) || (state == S_INTW);
    mem_addr   = mar;
    mem_wdata  = (state == S_WR) ? res_data : mbr;
    opnd_valid = (state == S_OPF) && mem_ready;
    opnd_data  = mem_rdata;
    exe_valid  = (state == S_EXE);
    instr_done = (state == S_ICK);
    irq_ack    = (state == S_INTW) && mem_ready;
  end
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int DW = 16,
  parameter int SAVE_ADDR = 'h3F0,
  localparam int AW = DW - 6
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          opnd_valid,
  input logic          exe_valid,
  input logic          exe_ready,
  input logic          irq_ack,
  input logic          instr_done
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !mem_req);

  assert_opnd_is_read_R4: assert property (@(posedge clk) disable iff (rst)
    opnd_valid |-> mem_req && mem_ready && !mem_we);

  assert_exe_no_mem_R6: assert property (@(posedge clk) disable iff (rst)
    exe_valid |-> !mem_req);

  assert_exe_hold_R6: assert property (@(posedge clk) disable iff (rst)
    exe_valid && !exe_ready |=> exe_valid);

  assert_ack_save_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> mem_req && mem_we && mem_ready && (mem_addr == AW'(SAVE_ADDR)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> !mem_req && !exe_valid);
endmodule

bind icc_ctrl icc_checker #(.DW(DW), .SAVE_ADDR(SAVE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .opnd_valid(opnd_valid),
  .exe_valid(exe_valid), .exe_ready(exe_ready), .irq_ack(irq_ack),
  .instr_done(instr_done)
);

// File: tb/sim_icc_ctrl.sv
`timescale 1ns/1ps
module sim_icc_ctrl;
  localparam int DW = 16;
  localparam int AW = 10;

  logic clk = 0, rst = 1;
  logic mem_req, mem_ready = 0, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic opnd_valid, exe_valid, exe_ready = 0, irq = 0, irq_ack, instr_done;
  logic [DW-1:0] opnd_data, res_data = '0;

  always #2.5 clk = ~clk;

  icc_ctrl u0 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .opnd_valid(opnd_valid), .opnd_data(opnd_data),
    .exe_valid(exe_valid), .exe_ready(exe_ready), .res_data(res_data),
    .irq(irq), .irq_ack(irq_ack), .instr_done(instr_done)
  );

  logic [DW-1:0] mem [1024];
  int lat = 0, wcnt = 0, elat = 0, ecnt = 0;
  logic          lg_we   [64];
  logic [AW-1:0] lg_addr [64];
  logic [DW-1:0] lg_data [64];
  logic [DW-1:0] op_log  [8];
  int lg_n = 0, op_n = 0, done_n = 0, ack_n = 0;
  int checks = 0, fails = 0;

  // memory and execution-unit model, driven away from the active edge
  always @(negedge clk) begin
    mem_ready = 0;
    if (!rst && mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1;
        wcnt = 0;
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata = mem[mem_addr];
        if (lg_n < 64) begin
          lg_we[lg_n] = mem_we;
          lg_addr[lg_n] = mem_addr;
          lg_data[lg_n] = mem_we ? mem_wdata : mem_rdata;
          lg_n++;
        end
      end else wcnt++;
    end
    exe_ready = 0;
    if (!rst && exe_valid) begin
      if (ecnt >= elat) begin exe_ready = 1; ecnt = 0; end
      else ecnt++;
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (opnd_valid && op_n < 8) begin op_log[op_n] = opnd_data; op_n++; end
      if (instr_done) done_n++;
      if (irq_ack) ack_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_acc(input string req, input int i, input logic we,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    checks++;
    if (i >= lg_n || lg_we[i] !== we || lg_addr[i] !== a || lg_data[i] !== d) begin
      fails++;
      if (i >= lg_n)
        $display("FAIL %s access %0d missing expected=%b/%h/%h", req, i, we, a, d);
      else
        $display("FAIL %s access %0d actual=%b/%h/%h expected=%b/%h/%h", req, i,
                 lg_we[i], lg_addr[i], lg_data[i], we, a, d);
    end
  endtask

  task automatic start(input int l, input int el, input logic irq_lvl, input logic [DW-1:0] res);
    @(negedge clk);
    rst = 1;
    lat = l; elat = el; irq = irq_lvl; res_data = res;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    wcnt = 0; ecnt = 0; lg_n = 0; op_n = 0; done_n = 0; ack_n = 0;
    rst = 0;
  endtask

  task automatic run_until(input int n);
    int guard = 0;
    while (done_n < n && guard < 3000) begin @(posedge clk); guard++; end
    if (done_n < n) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d instructions", done_n, n);
    end
  endtask

  task automatic t_reset_no_irq();
    start(1, 0, 1'b1, 16'h0);
    chk("R1 mem_req low in reset", {31'b0, mem_req}, 0);
    run_until(3);
    chk_acc("R1 first fetch", 0, 0, 10'h000, 16'h0);
    chk_acc("R2 fetch", 1, 0, 10'h001, 16'h0);
    chk_acc("R2 fetch", 2, 0, 10'h002, 16'h0);
    chk("R8 irq ignored while disabled", ack_n, 0);
    chk("R8 done count", done_n, 3);
  endtask

  task automatic t_two_operands();
    start(2, 3, 1'b0, 16'hBEEF);
    mem[0] = 16'h9020; mem[10'h20] = 16'h1111; mem[10'h21] = 16'h2222;
    run_until(2);
    chk_acc("R2 fetch", 0, 0, 10'h000, 16'h9020);
    chk_acc("R4 operand 0", 1, 0, 10'h020, 16'h1111);
    chk_acc("R4 operand 1", 2, 0, 10'h021, 16'h2222);
    chk_acc("R7 result write", 3, 1, 10'h020, 16'hBEEF);
    chk_acc("R3 next fetch once per access", 4, 0, 10'h001, 16'h0000);
    chk("R4 operand strobes", op_n, 2);
    chk("R4 operand value 0", {16'b0, op_log[0]}, 32'h1111);
    chk("R4 operand value 1", {16'b0, op_log[1]}, 32'h2222);
    chk("R6 no access during exe", lg_n, 5);
  endtask

  task automatic t_indirect();
    start(1, 1, 1'b0, 16'hCAFE);
    mem[0] = 16'h5830; mem[10'h30] = 16'h0055; mem[10'h55] = 16'h1234;
    run_until(2);
    chk_acc("R5 pointer for operand", 1, 0, 10'h030, 16'h0055);
    chk_acc("R5 indirect operand", 2, 0, 10'h055, 16'h1234);
    chk_acc("R5 pointer for result", 3, 0, 10'h030, 16'h0055);
    chk_acc("R5 indirect result", 4, 1, 10'h055, 16'hCAFE);
    chk_acc("R2 next fetch", 5, 0, 10'h001, 16'h0);
    chk("R4 operand value", {16'b0, op_log[0]}, 32'h1234);
  endtask

  task automatic t_clamped_counts();
    start(0, 0, 1'b0, 16'h7777);
    mem[0] = 16'hF010; mem[10'h10] = 16'h000A; mem[10'h11] = 16'h000B;
    run_until(2);
    chk_acc("R4 code3 operand 0", 1, 0, 10'h010, 16'h000A);
    chk_acc("R4 code3 operand 1", 2, 0, 10'h011, 16'h000B);
    chk_acc("R7 code3 result 0", 3, 1, 10'h010, 16'h7777);
    chk_acc("R7 code3 result 1", 4, 1, 10'h011, 16'h7777);
    chk_acc("R3 zero-wait fetch", 5, 0, 10'h001, 16'h0);
    chk("R3 access count", lg_n, 6);
  endtask

  task automatic t_interrupt();
    start(1, 0, 1'b1, 16'h0);
    mem[0] = 16'h0400;
    run_until(3);
    chk_acc("R10 enabling fetch", 0, 0, 10'h000, 16'h0400);
    chk_acc("R9 PC save write", 1, 1, 10'h3F0, 16'h0001);
    chk_acc("R9 handler fetch", 2, 0, 10'h100, 16'h0);
    chk_acc("R9 no re-entry", 3, 0, 10'h101, 16'h0);
    chk("R9 single ack", ack_n, 1);
    chk("R9 saved word in memory", {16'b0, mem[10'h3F0]}, 32'h0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL global watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset_no_irq();
    t_two_operands();
    t_indirect();
    t_clamped_counts();
    t_interrupt();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule